// File: doc/BRIEF.md
# Programmed-IO Audio Sample Port

This block is the host-polled data port of a stereo audio codec core. A host on an 8-bit asynchronous bus (active-low chip select, read strobe and write strobe) moves each audio sample as a run of bytes. On the capture side the core offers a complete multi-byte sample once per sample period. The port holds it and hands it out one byte per read strobe. On the playback side the port collects one byte per write strobe and passes the finished sample to the core in a single step.

Each direction has its own ready flag, which the host polls. The capture flag rises on the capture sample-period tick and the playback flag rises on the playback tick. Each flag drops once the last byte of its sample has moved. A direction takes part only when both its enable bit and its programmed-IO select bit are set, so the host can service capture and playback separately and in either order. Strobes and bus qualifiers are synchronised into the core clock. Each strobe moves the byte counter exactly once, whatever its length.

Top module: `audio_pio_port`

## Requirements
- R1: The capture direction is active only while `cap_en` and `cap_pio` are both 1. While it is inactive, `cap_ready` stays 0, `cap_tick` has no effect and `bus_oe` stays 0.
- R2: The playback direction is active only while `play_en` and `play_pio` are both 1. While it is inactive, write strobes change neither `play_sample` nor `play_load`, and `play_ready` stays 0.
- R3: A host cycle counts only while `cs_n` is 0 and both `cap_ack_n` and `play_ack_n` are 1. A strobe outside such a cycle neither drives the bus nor advances a byte counter.
- R4: `bus_oe` is 1 only while `rd_n` is 0 during a valid cycle with capture active. `bus_dout` then carries the capture byte selected by the counter, where byte k is bits [8k+7:8k] and byte 0 is read first.
- R5: A written byte is the value of `bus_din` while `wr_n` is low, taken at the rising edge of `wr_n`. A change of `bus_din` in the same instant as that edge is not taken. Byte k lands in bits [8k+7:8k] of the sample, byte 0 first.
- R6: A `cap_tick` while capture is active latches `cap_sample`, sets `cap_ready` and restarts the read counter at byte 0.
- R7: Reading the last byte clears `cap_ready`, unless a tick arrives in the same cycle. The next read then returns byte 0.
- R8: A `play_tick` while playback is active sets `play_ready`. The last written byte updates `play_sample` with all bytes, pulses `play_load` for one cycle and clears `play_ready`.
- R9: Each valid strobe advances its byte counter exactly once, however many clock cycles the strobe stays low.
- R10: Capture and playback are independent. Neither ready flag and neither transfer waits on the other direction's flag.
- R11: Clearing a direction's enable or select bit clears its ready flag and returns its byte counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| cap_ack_n | input | 1 | Capture DMA acknowledge, must be high for a programmed cycle |
| play_ack_n | input | 1 | Playback DMA acknowledge, must be high for a programmed cycle |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_oe | output | 1 | Enable for the port's bus drivers |
| cap_en | input | 1 | Capture enable bit |
| cap_pio | input | 1 | Capture programmed-IO select bit |
| play_en | input | 1 | Playback enable bit |
| play_pio | input | 1 | Playback programmed-IO select bit |
| cap_tick | input | 1 | One-cycle capture sample-period tick |
| play_tick | input | 1 | One-cycle playback sample-period tick |
| cap_sample | input | 8*SAMPLE_BYTES | Capture sample from the core |
| play_sample | output | 8*SAMPLE_BYTES | Last complete playback sample |
| play_load | output | 1 | One-cycle pulse when play_sample is updated |
| cap_ready | output | 1 | Capture sample waiting to be read |
| play_ready | output | 1 | Port ready for the next playback sample |

## Verification
The bench builds the port with SAMPLE_BYTES set to 3 and SYNC_STAGES set to 2. A three-byte sample makes the counter wrap at a value that is not a power of two, so the unused counter code has to be skipped. It also puts a middle byte between the first and last ones, which tests byte placement beyond a simple swap. Two synchronizer stages keep each strobe short while still leaving the strobe-to-counter latency long enough that stretched strobes, same-instant data changes and qualifier drops show whether the counter moves once or not at all.

// File: rtl/audio_pio_pkg.sv
package audio_pio_pkg;

  typedef logic [7:0] byte_t;

  // Snapshot of the asynchronous host pins, moved through the synchronizer as one word.
  typedef struct packed {
    logic  cs_n;
    logic  rd_n;
    logic  wr_n;
    logic  cap_ack_n;
    logic  play_ack_n;
    byte_t data;
  } bus_snap_t;

  localparam bus_snap_t BUS_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                     cap_ack_n: 1'b1, play_ack_n: 1'b1, data: 8'h00};

  function automatic logic cycle_ok(input bus_snap_t s);
    return !s.cs_n && s.cap_ack_n && s.play_ack_n;
  endfunction

endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync
  import audio_pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bus_snap_t pins,
  output logic      rd_fire,
  output logic      wr_fire,
  output byte_t     wr_byte
);

  bus_snap_t [SYNC_STAGES:0] chain;
  bus_snap_t                 prev_q;
  bus_snap_t                 cur;

  assign chain[0] = pins;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= BUS_IDLE;
      else        chain[g+1] <= chain[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= BUS_IDLE;
    else        prev_q <= cur;
  end

  assign cur = chain[SYNC_STAGES];

  // Completion is the low-to-high step; the qualifiers and data come from the strobe-low sample.
  always_comb begin
    rd_fire = !prev_q.rd_n && cur.rd_n && cycle_ok(prev_q);
    wr_fire = !prev_q.wr_n && cur.wr_n && cycle_ok(prev_q);
    wr_byte = prev_q.data;
  end

  assert_single_read_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_fire);
  assert_single_write_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

endmodule

// File: rtl/pio_capture_path.sv
module pio_capture_path
  import audio_pio_pkg::*;
#(
  parameter int SAMPLE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      tick,
  input  logic [8*SAMPLE_BYTES-1:0] sample_in,
  input  logic                      rd_fire,
  input  logic                      rd_now,
  output byte_t                     dout,
  output logic                      oe,
  output logic                      ready
);

  localparam int IW = (SAMPLE_BYTES > 1) ? $clog2(SAMPLE_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(SAMPLE_BYTES - 1);

  byte_t [SAMPLE_BYTES-1:0] hold_q, hold_d;
  logic  [IW-1:0]           idx_q, idx_d;
  logic                     ready_q, ready_d;
  logic                     hold_en;

  always_comb begin
    idx_d   = idx_q;
    ready_d = ready_q;
    hold_d  = hold_q;
    hold_en = 1'b0;
    if (!active) begin
      idx_d   = '0;
      ready_d = 1'b0;
    end else begin
      if (rd_fire) begin
        if (idx_q == LAST) begin
          idx_d   = '0;
          ready_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      if (tick) begin
        hold_d  = sample_in;
        hold_en = 1'b1;
        idx_d   = '0;
        ready_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign dout  = hold_q[idx_q];
  assign oe    = active && rd_now;
  assign ready = ready_q;

  assert_cap_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  assert_cap_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ready_q && idx_q == '0));
  assert_cap_tick_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick) |=> (ready_q && idx_q == '0));
  assert_cap_last_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rd_fire && idx_q == LAST && !tick) |=> (!ready_q && idx_q == '0));

endmodule

// File: rtl/pio_playback_path.sv
module pio_playback_path
  import audio_pio_pkg::*;
#(
  parameter int SAMPLE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      active,
  input  logic                      tick,
  input  logic                      wr_fire,
  input  byte_t                     wr_byte,
  output logic [8*SAMPLE_BYTES-1:0] sample_out,
  output logic                      load,
  output logic                      ready
);

  localparam int IW = (SAMPLE_BYTES > 1) ? $clog2(SAMPLE_BYTES) : 1;
  localparam logic [IW-1:0] LAST = IW'(SAMPLE_BYTES - 1);

  byte_t [SAMPLE_BYTES-1:0] asm_q, asm_d, out_q, out_d;
  logic  [IW-1:0]           idx_q, idx_d;
  logic                     ready_q, ready_d, load_q, load_d;
  logic                     asm_en, out_en;

  always_comb begin
    asm_d   = asm_q;
    out_d   = out_q;
    idx_d   = idx_q;
    ready_d = ready_q;
    load_d  = 1'b0;
    asm_en  = 1'b0;
    out_en  = 1'b0;
    if (!active) begin
      idx_d   = '0;
      ready_d = 1'b0;
    end else begin
      if (wr_fire) begin
        asm_d[idx_q] = wr_byte;
        asm_en       = 1'b1;
        if (idx_q == LAST) begin
          out_d   = asm_d;
          out_en  = 1'b1;
          load_d  = 1'b1;
          ready_d = 1'b0;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      if (tick) ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ready_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      ready_q <= ready_d;
      load_q  <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asm_q <= '0;
    else if (asm_en) asm_q <= asm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  assign sample_out = out_q;
  assign load       = load_q;
  assign ready      = ready_q;

  assert_play_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST);
  assert_play_off_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ready_q && idx_q == '0 && !load_q));
  assert_play_last_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wr_fire && idx_q == LAST && !tick) |=> (load_q && !ready_q));
  assert_play_out_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_q |-> $stable(out_q));

endmodule

// File: rtl/audio_pio_port.sv
module audio_pio_port
  import audio_pio_pkg::*;
#(
  parameter int SAMPLE_BYTES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic                      cap_ack_n,
  input  logic                      play_ack_n,
  input  logic [7:0]                bus_din,
  output logic [7:0]                bus_dout,
  output logic                      bus_oe,
  input  logic                      cap_en,
  input  logic                      cap_pio,
  input  logic                      play_en,
  input  logic                      play_pio,
  input  logic                      cap_tick,
  input  logic                      play_tick,
  input  logic [8*SAMPLE_BYTES-1:0] cap_sample,
  output logic [8*SAMPLE_BYTES-1:0] play_sample,
  output logic                      play_load,
  output logic                      cap_ready,
  output logic                      play_ready
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  bus_snap_t pins;
  logic      rd_fire, wr_fire, rd_now;
  byte_t     wr_byte;
  logic      cap_active, play_active;

  assign pins        = '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, cap_ack_n: cap_ack_n,
                         play_ack_n: play_ack_n, data: bus_din};
  assign rd_now      = cycle_ok(pins) && !rd_n;
  assign cap_active  = cap_en && cap_pio;
  assign play_active = play_en && play_pio;

  pio_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(core_rst_n), .pins(pins),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .wr_byte(wr_byte)
  );

  pio_capture_path #(.SAMPLE_BYTES(SAMPLE_BYTES)) cap_i (
    .clk(clk), .rst_n(core_rst_n), .active(cap_active), .tick(cap_tick),
    .sample_in(cap_sample), .rd_fire(rd_fire), .rd_now(rd_now),
    .dout(bus_dout), .oe(bus_oe), .ready(cap_ready)
  );

  pio_playback_path #(.SAMPLE_BYTES(SAMPLE_BYTES)) play_i (
    .clk(clk), .rst_n(core_rst_n), .active(play_active), .tick(play_tick),
    .wr_fire(wr_fire), .wr_byte(wr_byte),
    .sample_out(play_sample), .load(play_load), .ready(play_ready)
  );

  assert_oe_needs_read_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    bus_oe |-> (!rd_n && !cs_n && cap_active));
  assert_oe_needs_acks_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    bus_oe |-> (cap_ack_n && play_ack_n));

endmodule

// File: tb/audio_pio_port_tb_top.sv
`timescale 1ns/1ps
module audio_pio_port_tb_top;

  localparam int NB = 3;
  localparam int SW = 8 * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, rd_n, wr_n, cap_ack_n, play_ack_n;
  logic [7:0]    bus_din, bus_dout;
  logic          bus_oe;
  logic          cap_en, cap_pio, play_en, play_pio, cap_tick, play_tick;
  logic [SW-1:0] cap_sample, play_sample;
  logic          play_load, cap_ready, play_ready;

  int checks = 0;
  int errors = 0;
  int loads  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  audio_pio_port #(.SAMPLE_BYTES(NB), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cap_ack_n(cap_ack_n), .play_ack_n(play_ack_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .cap_en(cap_en), .cap_pio(cap_pio),
    .play_en(play_en), .play_pio(play_pio), .cap_tick(cap_tick), .play_tick(play_tick),
    .cap_sample(cap_sample), .play_sample(play_sample), .play_load(play_load),
    .cap_ready(cap_ready), .play_ready(play_ready)
  );

  always @(posedge clk) if (rst_n && play_load) loads++;

  localparam logic [SW-1:0] CAP_VEC [4]  = '{24'hA1B2C3, 24'h000000, 24'hFF0180, 24'h5A5AA5};
  localparam logic [SW-1:0] PLAY_VEC [4] = '{24'h123456, 24'hFFFFFF, 24'h80FE01, 24'h0F0F70};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit cap);
    @(negedge clk);
    if (cap) cap_tick = 1'b1; else play_tick = 1'b1;
    @(negedge clk);
    cap_tick = 1'b0;
    play_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic host_read(input int hold, output logic [7:0] val, output logic oe);
    @(negedge clk);
    cs_n = 1'b0;
    rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    val = bus_dout;
    oe  = bus_oe;
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] val);
    @(negedge clk);
    cs_n    = 1'b0;
    bus_din = val;
    wr_n    = 1'b0;
    repeat (4) @(negedge clk);
    wr_n    = 1'b1;
    bus_din = ~val;
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       oe;
    int         l0;
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    cap_ack_n = 1'b1; play_ack_n = 1'b1; bus_din = 8'h00;
    cap_en = 1'b0; cap_pio = 1'b0; play_en = 1'b0; play_pio = 1'b0;
    cap_tick = 1'b0; play_tick = 1'b0; cap_sample = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset cap_ready", cap_ready, 0);
    check("R2 reset play_ready", play_ready, 0);
    check("R8 reset play_load", play_load, 0);
    check("R4 reset bus_oe", bus_oe, 0);

    cap_en = 1'b1; cap_pio = 1'b1; play_en = 1'b1; play_pio = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cap_sample = CAP_VEC[i];
      pulse(1'b1);
      cap_sample = ~CAP_VEC[i];
      check("R6 tick sets cap_ready", cap_ready, 1);
      for (int k = 0; k < NB; k++) begin
        host_read(4, v, oe);
        check("R4 read oe", oe, 1);
        check("R4 read byte", v, CAP_VEC[i][8*k +: 8]);
      end
      check("R7 last read clears cap_ready", cap_ready, 0);
      pulse(1'b0);
      check("R8 tick sets play_ready", play_ready, 1);
      l0 = loads;
      for (int k = 0; k < NB; k++) host_write(PLAY_VEC[i][8*k +: 8]);
      check("R5 play_sample", play_sample, PLAY_VEC[i]);
      check("R8 one load pulse", loads - l0, 1);
      check("R8 last write clears play_ready", play_ready, 0);
    end

    // R1: select bit off
    cap_pio = 1'b0;
    cap_sample = 24'hCCBBAA;
    pulse(1'b1);
    check("R1 inactive tick ignored", cap_ready, 0);
    host_read(4, v, oe);
    check("R1 inactive no drive", oe, 0);
    cap_pio = 1'b1;

    // R2: playback select off
    play_pio = 1'b0;
    l0 = loads;
    for (int k = 0; k < NB; k++) host_write(8'h77);
    check("R2 no load when inactive", loads - l0, 0);
    check("R2 sample unchanged", play_sample, PLAY_VEC[3]);
    pulse(1'b0);
    check("R2 play_ready held low", play_ready, 0);
    play_pio = 1'b1;

    // R3: qualifiers
    pulse(1'b1);
    cap_ack_n = 1'b0;
    host_read(4, v, oe);
    check("R3 ack low no drive", oe, 0);
    cap_ack_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 cs high no drive", bus_oe, 0);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    host_read(4, v, oe);
    check("R3 counter not advanced", v, 8'hAA);

    // R9: stretched strobe advances once
    host_read(25, v, oe);
    check("R9 long strobe byte", v, 8'hBB);
    host_read(4, v, oe);
    check("R9 next byte after long strobe", v, 8'hCC);

    // R11: disable mid-sample
    cap_sample = 24'h665544;
    pulse(1'b1);
    host_read(4, v, oe);
    cap_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 disable clears cap_ready", cap_ready, 0);
    cap_en = 1'b1;
    cap_sample = 24'h998877;
    pulse(1'b1);
    host_read(4, v, oe);
    check("R11 counter restarted", v, 8'h77);

    // R10: playback while capture still pending
    check("R10 capture pending", cap_ready, 1);
    pulse(1'b0);
    l0 = loads;
    host_write(8'h10); host_write(8'h20); host_write(8'h30);
    check("R10 playback independent", play_sample, 24'h302010);
    check("R10 load independent", loads - l0, 1);
    check("R10 capture flag untouched", cap_ready, 1);
    host_read(4, v, oe);
    check("R10 capture continues", v, 8'h88);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule